// File: doc/BRIEF.md
# Periodic Tick Interrupt Timer

This block turns a slow reference-tick enable into a programmable periodic interrupt. A single control register holds an enable flag in its top bit and a period value in the bits below it. While the flag is set, the block counts reference ticks and raises a one-cycle interrupt pulse each time the programmed value plus one ticks have gone by. It then reloads the same period and keeps running.

Software reads and writes the control register over a minimal register bus: a write strobe with write data, and a read-data bus that always shows the stored register. Every write restarts the period from the beginning. If the written value has the enable flag set, the next interrupt arrives one full new period after the write. A build parameter selects whether the period is tracked by a down counter or an up counter. Both choices give the same behaviour at the ports.

Top module: `periodic_tick_irq`

## Requirements
- R1: After reset the control register reads 0x00 and no interrupt is produced until software sets the enable bit.
- R2: `bus_rdata` returns all eight bits of the last written value unchanged, from the cycle after the write strobe onward.
- R3: With bit 7 of the register set and bits 6:0 equal to P, `irq_pulse` is asserted once every P+1 reference ticks. The pulse is asserted in the same clock cycle as the reference tick that completes the period.
- R4: After each interrupt the timer reloads the same period and continues, so successive interrupts stay exactly P+1 ticks apart.
- R5: Any write with bit 7 set restarts the count using the newly written period. This holds even when the timer was already running and only bits 6:0 change. The next interrupt comes on the (new P)+1-th reference tick after the write.
- R6: While bit 7 is clear, `irq_pulse` stays low whatever the reference tick does.
- R7: In a cycle with the write strobe high, a reference tick is not counted and `irq_pulse` stays low.
- R8: `irq_pulse` is high only in cycles where `ref_tick` is high, so each pulse lasts one system clock cycle.
- R9: With a period value of 0 and the enable bit set, every reference tick produces an interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle enable marking each reference crystal period |
| bus_wr | input | 1 | Write strobe for the control register |
| bus_wdata | input | 8 | Write data: bit 7 is the enable, bits 6:0 are the period value |
| bus_rdata | output | 8 | Current contents of the control register |
| irq_pulse | output | 1 | One-cycle periodic interrupt pulse |

## Verification
A write becomes visible on `bus_rdata` one clock edge after the strobe. The interrupt is combinational on the tick that completes the period: the pulse appears in the same cycle as that `ref_tick`, with no registered delay. The bench therefore drives inputs on the falling edge and samples both outputs shortly after it, before the rising edge that commits the state. It compares them with a tick-accurate reference model that is advanced after each rising edge. Directed sequences also count reference ticks between pulses to confirm the P+1 spacing, the restart on write and the behaviour of a write that collides with a tick.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

   // Selects how the period counter tracks progress through a period.
   typedef enum logic [0:0] {
      TICK_CNT_DOWN = 1'b0,
      TICK_CNT_UP   = 1'b1
   } tick_cnt_style_e;

endpackage

// File: rtl/tick_ctl_reg.sv
module tick_ctl_reg #(
   parameter int REG_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] ctl_q,
   output logic             run_q,
   output logic [REG_W-2:0] period_q
);

   localparam int PER_W = REG_W - 1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
      end else if (wr_en) begin
         ctl_q <= wr_data;
      end
   end

   assign run_q    = ctl_q[REG_W-1];
   assign period_q = ctl_q[PER_W-1:0];

   // The stored register mirrors the written word one edge later.
   assert_readback_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (ctl_q == $past(wr_data)));

   // Without a write the register keeps its value.
   assert_hold_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(ctl_q));

endmodule

// File: rtl/tick_period_cnt.sv
module tick_period_cnt
   import tick_timer_pkg::*;
#(
   parameter int              PER_W = 7,
   parameter tick_cnt_style_e STYLE = TICK_CNT_DOWN
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic             load,
   input  logic [PER_W-1:0] load_val,
   input  logic [PER_W-1:0] period,
   output logic             fire
);

   logic [PER_W-1:0] cnt_q;
   logic             done;
   logic             adv;

   assign adv  = run & tick & ~load;
   assign fire = adv & done;

   generate
      if (STYLE == TICK_CNT_DOWN) begin : g_down
         // Holds the number of ticks still to pass before the period ends.
         assign done = (cnt_q == '0);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (load) begin
               cnt_q <= load_val;
            end else if (adv) begin
               cnt_q <= done ? period : cnt_q - 1'b1;
            end
         end

         assert_reload_R4 : assert property (@(posedge clk) disable iff (!rst_n)
            fire |=> (cnt_q == $past(period)));
      end else begin : g_up
         // Holds the number of ticks already passed in the current period.
         assign done = (cnt_q == period);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (load) begin
               cnt_q <= '0;
            end else if (adv) begin
               cnt_q <= done ? '0 : cnt_q + 1'b1;
            end
         end

         assert_reload_R4 : assert property (@(posedge clk) disable iff (!rst_n)
            fire |=> (cnt_q == '0));
      end
   endgenerate

   // The progress count never leaves the programmed period.
   assert_count_in_range_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= period);

   // A load always starts a fresh period.
   assert_restart_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !fire || ($past(load_val) == '0));

endmodule

// File: rtl/periodic_tick_irq.sv
module periodic_tick_irq
   import tick_timer_pkg::*;
#(
   parameter int              REG_W     = 8,
   parameter tick_cnt_style_e CNT_STYLE = TICK_CNT_DOWN
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_tick,
   input  logic             bus_wr,
   input  logic [REG_W-1:0] bus_wdata,
   output logic [REG_W-1:0] bus_rdata,
   output logic             irq_pulse
);

   localparam int PER_W = REG_W - 1;

   generate
      if (REG_W < 2 || REG_W > 32) begin : g_bad_width
         $error("periodic_tick_irq: REG_W must lie in 2..32");
      end
   endgenerate

   logic [REG_W-1:0] ctl_q;
   logic             run_q;
   logic [PER_W-1:0] period_q;
   logic             fire;

   tick_ctl_reg #(
      .REG_W(REG_W)
   ) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (bus_wr),
      .wr_data (bus_wdata),
      .ctl_q   (ctl_q),
      .run_q   (run_q),
      .period_q(period_q)
   );

   tick_period_cnt #(
      .PER_W(PER_W),
      .STYLE(CNT_STYLE)
   ) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run_q),
      .tick    (ref_tick),
      .load    (bus_wr),
      .load_val(bus_wdata[PER_W-1:0]),
      .period  (period_q),
      .fire    (fire)
   );

   assign bus_rdata = ctl_q;
   assign irq_pulse = fire;

   assert_irq_needs_tick_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |-> ref_tick);

   assert_irq_needs_enable_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |-> bus_rdata[REG_W-1]);

   assert_no_irq_on_write_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr |-> !irq_pulse);

   assert_every_tick_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rdata[REG_W-1] && bus_rdata[PER_W-1:0] == '0 && ref_tick && !bus_wr
       && !$past(bus_wr)) |-> irq_pulse);

endmodule

// File: tb/tb_periodic_tick_irq.sv
module tb_periodic_tick_irq;
   localparam int CLK_PERIOD = 10;
   localparam int SEED       = 20240611;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ref_tick = 1'b0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       irq_pulse;

   int checks = 0;
   int fails = 0;
   bit finished = 1'b0;
   logic last_irq;

   logic [7:0] m_reg = 8'h00;
   logic [6:0] m_rem = 7'h00;

   periodic_tick_irq dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .ref_tick (ref_tick),
      .bus_wr   (bus_wr),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .irq_pulse(irq_pulse)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic exp_irq(input logic tk, input logic wr);
      return m_reg[7] && tk && !wr && (m_rem == 7'd0);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // One cycle: drive on the falling edge, check before the rising edge, then advance the model.
   task automatic step(input logic tk, input logic wr, input logic [7:0] wd, input string req);
      logic e;
      @(negedge clk);
      ref_tick  = tk;
      bus_wr    = wr;
      bus_wdata = wd;
      #1;
      e = exp_irq(tk, wr);
      last_irq = irq_pulse;
      chk(irq_pulse === e, req, irq_pulse, e);
      chk(bus_rdata === m_reg, "R2 readback", bus_rdata, m_reg);
      @(posedge clk);
      if (wr) begin
         m_reg = wd;
         m_rem = wd[6:0];
      end else if (m_reg[7] && tk) begin
         m_rem = (m_rem == 7'd0) ? m_reg[6:0] : m_rem - 7'd1;
      end
   endtask

   task automatic ticks_to_irq(input int limit, output int n);
      n = 0;
      do begin
         step(1'b1, 1'b0, 8'h00, "R3 periodic");
         n++;
      end while (!last_irq && n < limit);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int n;
      int dummy;
      dummy = $urandom(SEED);
      // R1: reset state
      repeat (3) @(negedge clk);
      #1;
      chk(bus_rdata === 8'h00, "R1 reset value", bus_rdata, 0);
      chk(irq_pulse === 1'b0, "R1 no irq in reset", irq_pulse, 0);
      @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 8'h00, "R1 idle after reset");

      // R3/R4: period value 5 gives 6 ticks per interrupt
      step(1'b0, 1'b1, 8'h85, "R5 write");
      ticks_to_irq(300, n);
      chk(n == 6, "R3 first interval", n, 6);
      ticks_to_irq(300, n);
      chk(n == 6, "R4 reload interval", n, 6);
      ticks_to_irq(300, n);
      chk(n == 6, "R4 reload interval again", n, 6);

      // R9: period value 0
      step(1'b0, 1'b1, 8'h80, "R5 write");
      for (int i = 0; i < 5; i++) begin
         step(1'b1, 1'b0, 8'h00, "R9 every tick");
         chk(last_irq === 1'b1, "R9 pulse each tick", last_irq, 1);
      end

      // R3: largest period
      step(1'b1, 1'b1, 8'hFF, "R5 write");
      ticks_to_irq(300, n);
      chk(n == 128, "R3 max period", n, 128);

      // R6: disabled, register still readable
      step(1'b0, 1'b1, 8'h05, "R6 write");
      n = 0;
      for (int i = 0; i < 60; i++) begin
         step(1'b1, 1'b0, 8'h00, "R6 disabled");
         if (last_irq) n++;
      end
      chk(n == 0, "R6 no pulses when disabled", n, 0);
      chk(bus_rdata === 8'h05, "R2 disabled readback", bus_rdata, 8'h05);

      // R5: restart mid-period with a new period
      step(1'b0, 1'b1, 8'h8A, "R5 write");
      for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 8'h00, "R5 partial period");
      step(1'b0, 1'b1, 8'h83, "R5 rewrite");
      ticks_to_irq(300, n);
      chk(n == 4, "R5 restart with new period", n, 4);

      // R7: write collides with the completing tick
      step(1'b0, 1'b1, 8'h82, "R7 write");
      step(1'b1, 1'b0, 8'h00, "R7 tick");
      step(1'b1, 1'b0, 8'h00, "R7 tick");
      step(1'b1, 1'b1, 8'h82, "R7 colliding write");
      chk(last_irq === 1'b0, "R7 no irq on write cycle", last_irq, 0);
      ticks_to_irq(300, n);
      chk(n == 3, "R7 tick on write not counted", n, 3);

      // R8: idle cycles between ticks carry no pulse
      step(1'b0, 1'b1, 8'h80, "R8 write");
      for (int i = 0; i < 10; i++) begin
         step(1'b0, 1'b0, 8'h00, "R8 no tick");
         chk(last_irq === 1'b0, "R8 pulse only with tick", last_irq, 0);
      end

      // Random mix against the model (R3, R4, R5, R6, R7)
      for (int i = 0; i < 20000; i++) begin
         logic tk;
         logic wr;
         logic [7:0] wd;
         tk = ($urandom % 3) == 0;
         wr = ($urandom % 150) == 0;
         wd = 8'($urandom);
         if (wd[6]) wd[5:0] = wd[5:0] & 6'h07;
         step(tk, wr, wd, "R3 random model");
      end

      finish_run();
   end
endmodule